// File: doc/BRIEF.md
# Supply Fail Delay Supervisor

This block qualifies supply faults before acting on them. Two comparator flags, one for a supply that is too low and one for a supply that is too high, arrive already synchronous to the block clock. Each flag has its own delay timer, which advances only on single-cycle pulses from a slow time base. A fault that stays present for its full delay blocks every output driver through a global disable. The same fault also sets a sticky supply-fail flag, which software reads as bit 15 of the device status word.

The undervoltage delay is a fixed number of ticks. The overvoltage delay has two settings, chosen by a select bit held in the control register. When the supply comes back in range, the global disable drops in the same cycle and no software action is needed. The supply-fail flag stays set until the host pulses a status clear. A clear that arrives while an expired fault is still present cannot remove the flag. Each delay is a tick-count parameter, so the tick rate sets the real time. For example, with a 4 kHz tick, 84 ticks give about 21 ms and 21 ticks give about 5.25 ms.

Top module: `supply_fail_supervisor`

## Requirements
- R1: After synchronous reset, `supply_fail` and `drive_off` are both 0.
- R2: While `uv_flag` stays high, `drive_off` stays 0 through the first UV_TICKS-1 tick pulses. It goes high in the clock cycle right after the edge that samples the UV_TICKS-th tick.
- R3: While `ov_flag` stays high, `drive_off` goes high after OV_LONG_TICKS ticks when `ov_long_sel` is 1, and after OV_SHORT_TICKS ticks when `ov_long_sel` is 0.
- R4: The undervoltage delay is UV_TICKS for both values of `ov_long_sel`.
- R5: If a fault flag goes low before its delay completes, its timer restarts from zero and nothing is latched. The next fault then needs its full delay again.
- R6: `supply_fail` goes high one clock edge after `drive_off` rises.
- R7: `drive_off` is low in any cycle in which neither fault flag is high. It falls in the same cycle the fault flags clear, with no status clear needed.
- R8: Once set, `supply_fail` stays high until a cycle with `status_clr` high and no expired fault present. The flag is 0 after that edge.
- R9: A `status_clr` pulse while an expired fault is still present leaves `supply_fail` high, and `drive_off` stays high.
- R10: Only cycles with `tick` high advance a timer. Any number of cycles without a tick do not change a timer.
- R11: The two timers run independently. `drive_off` is high while either flag is high with its delay complete, and it stays low while only a not-yet-expired fault remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_flag | input | 1 | Undervoltage comparator flag, synchronised |
| ov_flag | input | 1 | Overvoltage comparator flag, synchronised |
| ov_long_sel | input | 1 | Overvoltage delay select: 1 long, 0 short |
| status_clr | input | 1 | Single-cycle status clear request from the host |
| tick | input | 1 | Single-cycle time-base pulse that advances the timers |
| supply_fail | output | 1 | Sticky supply-fail flag (status bit 15) |
| drive_off | output | 1 | Global disable for all output drivers |

## Verification
Two functions can act on the fail flag in the same cycle: the host's status clear and a timer reaching its delay. The bench provokes this by pulsing `status_clr` in the same cycle as the final tick of an undervoltage delay, while the flag is still set from an earlier overvoltage event. The expected result is that the clear takes effect at that edge, with the flag at 0 and `drive_off` already at 1. At the following edge the new expiry sets the flag again, so the fault is never lost. A second case pulses the clear while an expired fault is still active; here the flag must not drop at all.

// File: rtl/supfail_pkg.sv
package supfail_pkg;

    // channel order inside the fault vector
    typedef enum logic [0:0] {
        CH_UV = 1'b0,
        CH_OV = 1'b1
    } fault_ch_e;

    localparam int NUM_CH = 2;

    // per-channel timer view handed to the top
    typedef struct packed {
        logic active;   // fault flag present this cycle
        logic expired;  // present and delay complete
    } ch_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/delay_limit_sel.sv
module delay_limit_sel
    import supfail_pkg::*;
#(
    parameter int CH_IDX         = 0,
    parameter int UV_TICKS       = 84,
    parameter int OV_LONG_TICKS  = 84,
    parameter int OV_SHORT_TICKS = 21,
    parameter int CW             = 7
) (
    input  logic          long_sel,
    output logic [CW-1:0] limit
);

    localparam logic [CW-1:0] UV_LIM  = CW'(UV_TICKS);
    localparam logic [CW-1:0] OVL_LIM = CW'(OV_LONG_TICKS);
    localparam logic [CW-1:0] OVS_LIM = CW'(OV_SHORT_TICKS);

    generate
        if (CH_IDX == int'(CH_OV)) begin : g_ov
            assign limit = long_sel ? OVL_LIM : OVS_LIM;
        end else begin : g_uv
            logic unused_sel;
            assign unused_sel = long_sel;
            assign limit      = UV_LIM;
        end
    endgenerate

endmodule

// File: rtl/fault_delay_timer.sv
module fault_delay_timer
    import supfail_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          fault,
    input  logic [CW-1:0] limit,
    output ch_state_t     st
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !fault) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        st.active  = fault;
        st.expired = fault && (cnt_q >= limit);
    end

    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && !tick) |=> $stable(cnt_q));

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        !fault |=> (cnt_q == '0));

    // R2
    expire_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(st.expired) && $stable(limit)) |-> $past(tick));

endmodule

// File: rtl/fail_latch.sv
module fail_latch
    import supfail_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] expired,
    input  logic         clr,
    output logic         fail
);

    logic any_exp;
    assign any_exp = |expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            fail <= 1'b0;
        end else begin
            fail <= any_exp | (fail & ~clr);
        end
    end

    // R6
    set_after_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        any_exp |=> fail);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && !clr) |=> fail);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !any_exp) |=> !fail);

endmodule

// File: rtl/supply_fail_supervisor.sv
module supply_fail_supervisor
    import supfail_pkg::*;
#(
    parameter int UV_TICKS       = 84,
    parameter int OV_LONG_TICKS  = 84,
    parameter int OV_SHORT_TICKS = 21
) (
    input  logic clk,
    input  logic rst,
    input  logic uv_flag,
    input  logic ov_flag,
    input  logic ov_long_sel,
    input  logic status_clr,
    input  logic tick,
    output logic supply_fail,
    output logic drive_off
);

    localparam int MAX_TICKS = max2(UV_TICKS, max2(OV_LONG_TICKS, OV_SHORT_TICKS));
    localparam int CW        = cnt_width(MAX_TICKS);

    logic [NUM_CH-1:0] fault_vec;
    logic [NUM_CH-1:0] exp_vec;
    logic [NUM_CH-1:0] act_vec;
    ch_state_t         st [NUM_CH];

    assign fault_vec[CH_UV] = uv_flag;
    assign fault_vec[CH_OV] = ov_flag;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            logic [CW-1:0] lim;

            delay_limit_sel #(
                .CH_IDX         (g),
                .UV_TICKS       (UV_TICKS),
                .OV_LONG_TICKS  (OV_LONG_TICKS),
                .OV_SHORT_TICKS (OV_SHORT_TICKS),
                .CW             (CW)
            ) i_lim (
                .long_sel (ov_long_sel),
                .limit    (lim)
            );

            fault_delay_timer #(
                .CW (CW)
            ) i_tmr (
                .clk   (clk),
                .rst   (rst),
                .tick  (tick),
                .fault (fault_vec[g]),
                .limit (lim),
                .st    (st[g])
            );

            assign exp_vec[g] = st[g].expired;
            assign act_vec[g] = st[g].active;
        end
    endgenerate

    assign drive_off = |(exp_vec & act_vec);

    fail_latch #(
        .N (NUM_CH)
    ) i_latch (
        .clk     (clk),
        .rst     (rst),
        .expired (exp_vec),
        .clr     (status_clr),
        .fail    (supply_fail)
    );

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (!uv_flag && !ov_flag) |-> !drive_off);

    // R9
    clr_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (status_clr && drive_off) |=> supply_fail);

endmodule

// File: tb/test_supply_fail_supervisor.sv
module test_supply_fail_supervisor;

    localparam int UVT  = 84;
    localparam int OVLT = 84;
    localparam int OVST = 21;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic uv = 1'b0, ov = 1'b0, sel = 1'b1, clr = 1'b0, tick = 1'b0;
    logic supply_fail, drive_off;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    supply_fail_supervisor #(
        .UV_TICKS       (UVT),
        .OV_LONG_TICKS  (OVLT),
        .OV_SHORT_TICKS (OVST)
    ) i_supply_fail_supervisor (
        .clk         (clk),
        .rst         (rst),
        .uv_flag     (uv),
        .ov_flag     (ov),
        .ov_long_sel (sel),
        .status_clr  (clr),
        .tick        (tick),
        .supply_fail (supply_fail),
        .drive_off   (drive_off)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) pulse_tick();
    endtask

    task automatic final_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic cleanup();
        uv = 1'b0;
        ov = 1'b0;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 supply_fail", supply_fail, 1'b0);
        chk("R1 drive_off", drive_off, 1'b0);
    endtask

    task automatic t_uv_basic();
        sel = 1'b1;
        uv  = 1'b1;
        run_ticks(UVT - 1);
        chk("R2 before delay", drive_off, 1'b0);
        final_tick();
        chk("R2 at delay", drive_off, 1'b1);
        chk("R6 flag not yet", supply_fail, 1'b0);
        @(negedge clk);
        chk("R6 flag set", supply_fail, 1'b1);
        uv = 1'b0;
        #1;
        chk("R7 release", drive_off, 1'b0);
        @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R8 sticky", supply_fail, 1'b1);
        chk("R7 stays off", drive_off, 1'b0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R8 cleared", supply_fail, 1'b0);
    endtask

    task automatic t_uv_sel_low();
        sel = 1'b0;
        uv  = 1'b1;
        run_ticks(UVT - 1);
        chk("R4 uv before delay sel=0", drive_off, 1'b0);
        final_tick();
        chk("R4 uv at delay sel=0", drive_off, 1'b1);
        cleanup();
        chk("R4 cleanup", supply_fail, 1'b0);
    endtask

    task automatic t_ov_sel(input logic s, input int n);
        sel = s;
        ov  = 1'b1;
        run_ticks(n - 1);
        chk("R3 ov before delay", drive_off, 1'b0);
        chk("R3 ov no flag yet", supply_fail, 1'b0);
        final_tick();
        chk("R3 ov at delay", drive_off, 1'b1);
        @(negedge clk);
        chk("R3 ov flag", supply_fail, 1'b1);
        cleanup();
    endtask

    task automatic t_abort();
        sel = 1'b0;
        ov  = 1'b1;
        run_ticks(OVST - 1);
        ov = 1'b0;
        @(negedge clk);
        chk("R5 no latch on abort", supply_fail, 1'b0);
        ov = 1'b1;
        run_ticks(OVST - 1);
        chk("R5 restarted timer", drive_off, 1'b0);
        chk("R5 flag clear", supply_fail, 1'b0);
        final_tick();
        chk("R5 full delay", drive_off, 1'b1);
        cleanup();
    endtask

    task automatic t_no_tick();
        uv = 1'b1;
        repeat (40) @(negedge clk);
        run_ticks(UVT - 1);
        repeat (40) @(negedge clk);
        chk("R10 idle cycles not counted", drive_off, 1'b0);
        final_tick();
        chk("R10 tick completes delay", drive_off, 1'b1);
        cleanup();
    endtask

    task automatic t_clr_active();
        uv = 1'b1;
        run_ticks(UVT);
        @(negedge clk);
        chk("R9 flag set", supply_fail, 1'b1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R9 flag kept", supply_fail, 1'b1);
        chk("R9 drive_off kept", drive_off, 1'b1);
        cleanup();
        chk("R9 clear after release", supply_fail, 1'b0);
    endtask

    task automatic t_coincident();
        sel = 1'b0;
        ov  = 1'b1;
        run_ticks(OVST);
        ov = 1'b0;
        @(negedge clk);
        chk("R8 flag from ov", supply_fail, 1'b1);
        uv = 1'b1;
        run_ticks(UVT - 1);
        tick = 1'b1;
        clr  = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        clr  = 1'b0;
        chk("R8 clear honoured", supply_fail, 1'b0);
        chk("R2 expiry same edge", drive_off, 1'b1);
        @(negedge clk);
        chk("R6 re-set after clear", supply_fail, 1'b1);
        cleanup();
    endtask

    task automatic t_both();
        sel = 1'b0;
        uv  = 1'b1;
        ov  = 1'b1;
        run_ticks(OVST);
        chk("R11 ov expires first", drive_off, 1'b1);
        ov = 1'b0;
        #1;
        chk("R11 uv not yet expired", drive_off, 1'b0);
        @(negedge clk);
        run_ticks(UVT - OVST - 1);
        chk("R11 uv still short", drive_off, 1'b0);
        final_tick();
        chk("R11 uv expires", drive_off, 1'b1);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_uv_basic();
        t_uv_sel_low();
        t_ov_sel(1'b1, OVLT);
        t_ov_sel(1'b0, OVST);
        t_abort();
        t_no_tick();
        t_clr_active();
        t_coincident();
        t_both();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule